// File: doc/BRIEF.md
# Compare Timer with Disable Bit

This block keeps a free-running 63-bit tick count and a 63-bit compare value. Both are held behind one 64-bit register view. The most significant bit of every 64-bit word written to either register is taken out of the value and kept as a single shared disable flag. Every 64-bit read returns the stored value with that flag placed back in the top bit. The count advances by one on each cycle in which the tick enable is high, whether the flag is set or clear.

When the block is armed and enabled, it produces a one-cycle match pulse once the advancing count reaches or passes the compare value. An interrupt arbiter uses this pulse to set its timer request bit. The match fires once per limit write. A limit of zero never arms it. A limit written below the running count fires on the next tick. Setting the flag cancels a pending match.

A parameter selects what the flag means to the rest of the core. In privilege mode, the flag is also presented as a lock output that restricts count reads to privileged code. In interrupt-disable mode, the lock output stays low and the flag only gates the match. A processor typically uses one privilege-mode instance and two interrupt-disable instances, and the two interrupt-disable instances feed one shared system-tick request. The intended tick rate is 100 MHz.

Top module: `cmp_timer`

## Requirements
- R1: While reset is asserted and after it is released, the flag is set, the count and the limit are zero, and the match output is low. A count read returns 64'h8000_0000_0000_0000 and a limit read returns the same value.
- R2: A write with `wr_sel`=0 loads `wr_data[62:0]` into the count and copies `wr_data[63]` into the flag. If a tick arrives in the same cycle, the written value wins.
- R3: `rd_data` is combinational. With `rd_sel`=0 it returns the count, and with `rd_sel`=1 it returns the limit. In both cases bit 63 equals the flag.
- R4: Each cycle with `tick_en` high and no write increments the count by one modulo 2^63, whatever the state of the flag.
- R5: A write with `wr_sel`=1 stores `wr_data[62:0]` as the limit and copies `wr_data[63]` into the flag. It arms the match only when the stored limit is nonzero and the flag is clear.
- R6: When a tick leaves the count greater than or equal to the limit while the block is armed and the flag is clear, `timer_hit` is high for exactly the following cycle.
- R7: After a match the block is disarmed. Further ticks produce no match until the limit is written again.
- R8: A limit written below the current count fires on the first tick after the write.
- R9: A limit of zero never produces a match.
- R10: A write that sets the flag cancels a pending match. Clearing the flag later through a count write does not re-arm the block.
- R11: With the default privilege mode, `priv_lock` equals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 limit |
| wr_data | input | 64 | Write word, bit 63 is the flag |
| rd_sel | input | 1 | Read target: 0 count, 1 limit |
| rd_data | output | 64 | Read word with the flag in bit 63 |
| timer_hit | output | 1 | One-cycle match pulse |
| priv_lock | output | 1 | Flag as privilege lock (privilege mode), else 0 |

## Verification
The main function is exercised with a limit that the count reaches exactly, a limit already passed, a zero limit, a limit written with the flag set, and a limit at the top of the count range just before the count wraps. These cases separate a correct match from four faults: a match that is missed, one that repeats, one that fires on a zero limit, and one that fires while disabled. Further tests cover a write and a tick in the same cycle, cancellation by the flag followed by re-enabling, and a reset while the block is armed. They show that the write takes priority over the tick and that the disarmed state persists.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic {
    FLAG_PRIV = 1'b0,
    FLAG_IRQ  = 1'b1
  } flag_mode_e;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cmp_timer_rst_sync.sv
module cmp_timer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int VW = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [VW-1:0] load_val,
  output logic [VW-1:0] cnt_o,
  output logic [VW-1:0] cnt_nxt_o
);
  logic [VW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  // R4: a lone tick moves the count forward by exactly one, wrapping
  assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && tick && !load) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cmp_timer_cmp.sv
module cmp_timer_cmp #(
  parameter int VW = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_lim,
  input  logic [VW-1:0] wr_val,
  input  logic          wr_flag,
  input  logic [VW-1:0] cnt_nxt,
  output logic          dis_o,
  output logic [VW-1:0] lim_o,
  output logic          hit_o
);
  logic          dis_q, dis_d;
  logic          arm_q, arm_d;
  logic          hit_q, hit_d;
  logic [VW-1:0] lim_q, lim_d;

  always_comb begin
    dis_d = dis_q;
    arm_d = arm_q;
    lim_d = lim_q;
    hit_d = 1'b0;
    if (wr_lim) begin
      lim_d = wr_val;
      dis_d = wr_flag;
      arm_d = (wr_val != '0) && !wr_flag;
    end else if (wr_cnt) begin
      dis_d = wr_flag;
      if (wr_flag) arm_d = 1'b0;
    end else if (tick && arm_q && !dis_q && (cnt_nxt >= lim_q)) begin
      hit_d = 1'b1;
      arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b1;
      arm_q <= 1'b0;
      lim_q <= '0;
      hit_q <= 1'b0;
    end else begin
      dis_q <= dis_d;
      arm_q <= arm_d;
      lim_q <= lim_d;
      hit_q <= hit_d;
    end
  end

  assign dis_o = dis_q;
  assign lim_o = lim_q;
  assign hit_o = hit_q;

  // R7: a match is a single-cycle pulse and leaves the block disarmed
  assert_hit_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q);

  // R10: a match only follows a cycle in which the block was armed and enabled
  assert_hit_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ($past(arm_q) && !$past(dis_q)));

  // R9: the block is never armed against a zero limit
  assert_armed_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> (lim_q != '0));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int         TMR_W     = 64,
  parameter flag_mode_e FLAG_MODE = FLAG_PRIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [TMR_W-1:0] rd_data,
  output logic             timer_hit,
  output logic             priv_lock
);
  localparam int VW = TMR_W - 1;

  logic          rst_n_i;
  logic          wr_cnt, wr_lim, tick_i;
  logic          dis;
  logic [VW-1:0] cnt, cnt_nxt, lim;

  cmp_timer_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign wr_cnt = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
  assign wr_lim = wr_en && (reg_sel_e'(wr_sel) == SEL_LIMIT);
  assign tick_i = tick_en && !wr_en;

  cmp_timer_count #(.VW(VW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .tick      (tick_i),
    .load      (wr_cnt),
    .load_val  (wr_data[VW-1:0]),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  cmp_timer_cmp #(.VW(VW)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick    (tick_i),
    .wr_cnt  (wr_cnt),
    .wr_lim  (wr_lim),
    .wr_val  (wr_data[VW-1:0]),
    .wr_flag (wr_data[VW]),
    .cnt_nxt (cnt_nxt),
    .dis_o   (dis),
    .lim_o   (lim),
    .hit_o   (timer_hit)
  );

  always_comb begin
    if (reg_sel_e'(rd_sel) == SEL_LIMIT) rd_data = {dis, lim};
    else                                 rd_data = {dis, cnt};
  end

  generate
    if (FLAG_MODE == FLAG_PRIV) begin : g_priv
      assign priv_lock = dis;
    end else begin : g_irq
      assign priv_lock = 1'b0;
    end
  endgenerate
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [63:0] rd_data;
  logic        timer_hit;
  logic        priv_lock;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .timer_hit(timer_hit), .priv_lock(priv_lock)
  );

  // op: 0 idle, 1 tick, 2 write count, 3 write limit
  typedef struct packed {
    logic [1:0]  op;
    logic        sel;
    logic [63:0] data;
    logic [63:0] exp_rd;
    logic        exp_hit;
    logic        exp_lock;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 64'h0,                   64'h8000_0000_0000_0000, 1'b0, 1'b1}, // R1
    '{2'd2, 1'b0, 64'h5,                   64'h5,                   1'b0, 1'b0}, // R2
    '{2'd3, 1'b1, 64'h8,                   64'h8,                   1'b0, 1'b0}, // R5
    '{2'd1, 1'b0, 64'h0,                   64'h6,                   1'b0, 1'b0}, // R4
    '{2'd1, 1'b0, 64'h0,                   64'h7,                   1'b0, 1'b0}, // R4
    '{2'd1, 1'b0, 64'h0,                   64'h8,                   1'b1, 1'b0}, // R6
    '{2'd1, 1'b0, 64'h0,                   64'h9,                   1'b0, 1'b0}, // R7
    '{2'd1, 1'b0, 64'h0,                   64'hA,                   1'b0, 1'b0}, // R7
    '{2'd3, 1'b1, 64'h3,                   64'h3,                   1'b0, 1'b0}, // R8
    '{2'd1, 1'b0, 64'h0,                   64'hB,                   1'b1, 1'b0}, // R8
    '{2'd3, 1'b1, 64'h0,                   64'h0,                   1'b0, 1'b0}, // R9
    '{2'd1, 1'b0, 64'h0,                   64'hC,                   1'b0, 1'b0}, // R9
    '{2'd3, 1'b1, 64'h8000_0000_0000_000E, 64'h8000_0000_0000_000E, 1'b0, 1'b1}, // R5
    '{2'd0, 1'b0, 64'h0,                   64'h8000_0000_0000_000C, 1'b0, 1'b1}, // R3
    '{2'd1, 1'b0, 64'h0,                   64'h8000_0000_0000_000D, 1'b0, 1'b1}, // R4
    '{2'd1, 1'b0, 64'h0,                   64'h8000_0000_0000_000E, 1'b0, 1'b1}, // R10
    '{2'd2, 1'b0, 64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFE, 1'b0, 1'b0}, // R2
    '{2'd3, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0}, // R5
    '{2'd1, 1'b0, 64'h0,                   64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0}, // R6
    '{2'd1, 1'b0, 64'h0,                   64'h0,                   1'b0, 1'b0}  // R4
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic sel, input logic [63:0] data,
                      input logic tk);
    @(negedge clk);
    rd_sel  = sel;
    wr_data = data;
    tick_en = (op == 2'd1) || tk;
    wr_en   = (op == 2'd2) || (op == 2'd3);
    wr_sel  = (op == 2'd3);
    @(posedge clk);
    #1;
    tick_en = 1'b0;
    wr_en   = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 hit in reset", {63'b0, timer_hit}, 64'h0);
    check("R1 count in reset", rd_data, 64'h8000_0000_0000_0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].sel, VECS[i].data, 1'b0);
      check($sformatf("R3 vec%0d rd_data", i), rd_data, VECS[i].exp_rd);
      check($sformatf("R6 vec%0d timer_hit", i), {63'b0, timer_hit}, {63'b0, VECS[i].exp_hit});
      check($sformatf("R11 vec%0d priv_lock", i), {63'b0, priv_lock}, {63'b0, VECS[i].exp_lock});
    end

    // R2: a count write in the same cycle as a tick loads the written value
    step(2'd2, 1'b0, 64'd100, 1'b1);
    check("R2 write beats tick", rd_data, 64'd100);

    // R10: setting the flag cancels; clearing it again does not re-arm
    step(2'd3, 1'b1, 64'd110, 1'b0);
    step(2'd2, 1'b0, 64'h8000_0000_0000_0069, 1'b0);
    step(2'd2, 1'b0, 64'd105, 1'b0);
    for (int k = 0; k < 10; k++) begin
      step(2'd1, 1'b0, 64'h0, 1'b0);
      check("R10 no hit after cancel", {63'b0, timer_hit}, 64'h0);
    end
    check("R10 count after ticks", rd_data, 64'd115);

    // R1: reset while armed disarms and restores the flag
    step(2'd3, 1'b1, 64'd120, 1'b0);
    @(negedge clk);
    rst_n  = 1'b0;
    rd_sel = 1'b0;
    #1;
    check("R1 count after async reset", rd_data, 64'h8000_0000_0000_0000);
    check("R1 lock after reset", {63'b0, priv_lock}, 64'h1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(2'd2, 1'b0, 64'd200, 1'b0);
    step(2'd1, 1'b0, 64'h0, 1'b0);
    check("R1 no hit after reset", {63'b0, timer_hit}, 64'h0);
    step(2'd0, 1'b1, 64'h0, 1'b0);
    check("R1 limit cleared", rd_data, 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule